// File: doc/BRIEF.md
# Virtual Address Region Decoder

This block sits in front of the translation lookaside buffer of a 32-bit memory management unit and is purely combinational. For each access it takes a virtual address, an access kind (data read, data write or instruction fetch), a privileged-mode flag and a translation-enable flag. It then sorts the address into one of a small set of fixed regions, and the region decides what happens next.

There are three possible results. The first is an untranslated physical address with read, write and execute permission. The second is an address-error indication with the exception code that a trap unit should raise. The third is a request that the TLB translate the address. The block also reports whether the region allows caching.

The 4 GiB space is divided on the top three address bits:

| Address range | Region |
|---|---|
| 0x00000000–0x7FFFFFFF | user region |
| 0x80000000–0x9FFFFFFF | cached kernel window |
| 0xA0000000–0xBFFFFFFF | uncached kernel window |
| 0xC0000000–0xDFFFFFFF | mapped kernel region |
| 0xE0000000–0xFFFFFFFF | control space |

Inside the control space, the first 64 MiB (0xE0000000–0xE3FFFFFF) is a store-queue window that user code may reach. The TLB lookup itself, exception vectoring and any cache-control register gating belong to other blocks.

Top module: `vad_region_decoder`

## Requirements
- R1: In privileged mode, an address in 0x80000000–0xBFFFFFFF bypasses translation. Its physical address is the virtual address with bits 31..29 cleared, and this holds whatever the translation-enable flag is.
- R2: In privileged mode, an address at or above 0xE0000000 bypasses translation and its physical address equals the virtual address unchanged.
- R3: In user mode, an address in 0x80000000–0xDFFFFFFF-excluded fixed regions (0x80000000–0xBFFFFFFF and 0xE4000000–0xFFFFFFFF) raises an address error. An address in 0xE0000000–0xE3FFFFFF bypasses with the address unchanged.
- R4: The access kind is encoded as 0 = data read, 1 = data write, 2 = fetch, and 3 is handled as a data read. The error-kind output is encoded as 0 = none, 1 = read error, 2 = write error, 3 = fetch error.
- R5: The exception code output is 0x0C0 for a read or fetch address error, 0x100 for a write address error, and 0x000 when there is no error.
- R6: With translation disabled, an address below 0x80000000 or in 0xC0000000–0xDFFFFFFF bypasses, with its physical address masked to the low 29 bits.
- R7: With translation enabled, an address below 0x80000000 or in 0xC0000000–0xDFFFFFFF asserts the need-translation output. It also drives bypass low, the physical address to zero and no error.
- R8: Read, write and execute permission are all granted exactly when bypass is asserted, and all three are zero otherwise.
- R9: In privileged mode, the cacheable flag is low for 0xA0000000–0xBFFFFFFF and for addresses at or above 0xE0000000, and high elsewhere. In user mode it is high only below 0x80000000.
- R10: The region checks of R1–R3 take precedence over the translation-enable flag. A user-mode access to 0x80000000 errors even with translation disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr_i | input | 32 | Virtual address of the access |
| acc_kind_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 treated as read |
| priv_i | input | 1 | 1 when the access runs in privileged mode |
| mmu_en_i | input | 1 | 1 when address translation is enabled |
| paddr_o | output | 32 | Untranslated physical address, zero unless bypass |
| bypass_o | output | 1 | Result is final without a TLB lookup |
| need_xlat_o | output | 1 | Address must be translated by the TLB |
| perm_rd_o | output | 1 | Read permission for the bypass result |
| perm_wr_o | output | 1 | Write permission for the bypass result |
| perm_ex_o | output | 1 | Execute permission for the bypass result |
| err_kind_o | output | 2 | Address-error kind: 0 none, 1 read, 2 write, 3 fetch |
| exc_code_o | output | 12 | Exception code for the error, zero if none |
| cacheable_o | output | 1 | Region permits caching |

## Verification
The hardest behaviour to reach is at the edges of the store-queue window in user mode. Its last word, 0xE3FFFFFC, must pass unchanged, while 0xE4000000 must error with a write-specific code. The bench drives both edges with different access kinds.

The same area needs a second approach. The precedence of region checks over the translation-enable flag only appears when a user-mode access to a kernel window is made with translation turned off. The bench drives that combination as well as the reserved access-kind encoding.

// File: rtl/vad_pkg.sv
// Shared types and constants for the virtual address region decoder.
// Assumes a 32-bit virtual address whose top three bits pick a 512 MiB area.
package vad_pkg;
    localparam int VA_W      = 32;
    localparam int AREA_W    = 3;
    localparam int SQ_TAG_W  = 6;
    localparam int EXC_W     = 12;
    localparam int LOW_W     = VA_W - AREA_W;

    localparam logic [SQ_TAG_W-1:0] SQ_TAG   = 6'b111000;
    localparam logic [EXC_W-1:0]    EXC_NONE = 12'h000;
    localparam logic [EXC_W-1:0]    EXC_RDEX = 12'h0C0;
    localparam logic [EXC_W-1:0]    EXC_WR   = 12'h100;

    typedef enum logic [2:0] {
        RGN_USER  = 3'd0,
        RGN_FIX_C = 3'd1,
        RGN_FIX_U = 3'd2,
        RGN_KMAP  = 3'd3,
        RGN_SQWIN = 3'd4,
        RGN_CTRL  = 3'd5
    } rgn_e;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_RD   = 2'd1,
        ERR_WR   = 2'd2,
        ERR_EX   = 2'd3
    } err_e;
endpackage

// File: rtl/vad_region_class.sv
// Sorts a virtual address into a fixed region.
// Assumes the area is given by the top AREA_W bits and the store-queue
// window by the top SQ_TAG_W bits; purely combinational.
module vad_region_class
    import vad_pkg::*;
(
    input  logic [VA_W-1:0] vaddr_i,
    output rgn_e            rgn_o
);
    logic [AREA_W-1:0] area;

    assign area = vaddr_i[VA_W-1 -: AREA_W];

    // Map the top address bits to a region.
    always_comb begin
        case (area)
            3'd4:    rgn_o = RGN_FIX_C;
            3'd5:    rgn_o = RGN_FIX_U;
            3'd6:    rgn_o = RGN_KMAP;
            3'd7:    rgn_o = (vaddr_i[VA_W-1 -: SQ_TAG_W] == SQ_TAG) ? RGN_SQWIN : RGN_CTRL;
            default: rgn_o = RGN_USER;
        endcase
    end
endmodule

// File: rtl/vad_access_check.sv
// Decides between bypass, address error and translation for one access.
// Assumes the region has already been classified; purely combinational.
module vad_access_check
    import vad_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr_i,
    input  rgn_e             rgn_i,
    input  logic [1:0]       acc_i,
    input  logic             priv_i,
    input  logic             mmu_en_i,
    output logic [VA_W-1:0]  paddr_o,
    output logic             bypass_o,
    output logic             need_xlat_o,
    output err_e             err_o,
    output logic [EXC_W-1:0] exc_o
);
    logic fixed_rgn;
    logic keep_full;
    logic user_block;
    logic [VA_W-1:0] masked;

    assign fixed_rgn  = (rgn_i == RGN_FIX_C) || (rgn_i == RGN_FIX_U) ||
                        (rgn_i == RGN_SQWIN) || (rgn_i == RGN_CTRL);
    assign keep_full  = (rgn_i == RGN_SQWIN) || (rgn_i == RGN_CTRL);
    assign user_block = !priv_i && fixed_rgn && (rgn_i != RGN_SQWIN);
    assign masked     = {{AREA_W{1'b0}}, vaddr_i[LOW_W-1:0]};

    // Resolve the outcome: region rules first, then the enable flag.
    always_comb begin
        paddr_o     = '0;
        bypass_o    = 1'b0;
        need_xlat_o = 1'b0;
        err_o       = ERR_NONE;
        exc_o       = EXC_NONE;
        if (user_block) begin
            case (acc_i)
                ACC_WR: begin err_o = ERR_WR; exc_o = EXC_WR;   end
                ACC_EX: begin err_o = ERR_EX; exc_o = EXC_RDEX; end
                default: begin err_o = ERR_RD; exc_o = EXC_RDEX; end
            endcase
        end else if (fixed_rgn) begin
            bypass_o = 1'b1;
            paddr_o  = keep_full ? vaddr_i : masked;
        end else if (!mmu_en_i) begin
            bypass_o = 1'b1;
            paddr_o  = masked;
        end else begin
            need_xlat_o = 1'b1;
        end
    end
endmodule

// File: rtl/vad_cache_attr.sv
// Reports whether a region allows caching for the current privilege.
// Assumes cache-control register gating is applied elsewhere.
module vad_cache_attr
    import vad_pkg::*;
(
    input  rgn_e rgn_i,
    input  logic priv_i,
    output logic cacheable_o
);
    // Privileged: uncached window and control space are not cacheable.
    always_comb begin
        if (priv_i)
            cacheable_o = !((rgn_i == RGN_FIX_U) || (rgn_i == RGN_SQWIN) ||
                            (rgn_i == RGN_CTRL));
        else
            cacheable_o = (rgn_i == RGN_USER);
    end
endmodule

// File: rtl/vad_region_decoder.sv
// Top of the virtual address region decoder: classifies the address,
// resolves bypass/error/translation and the cacheable attribute.
// Assumes all inputs are stable within a cycle; no state is held.
module vad_region_decoder
    import vad_pkg::*;
(
    input  logic [31:0] vaddr_i,
    input  logic [1:0]  acc_kind_i,
    input  logic        priv_i,
    input  logic        mmu_en_i,
    output logic [31:0] paddr_o,
    output logic        bypass_o,
    output logic        need_xlat_o,
    output logic        perm_rd_o,
    output logic        perm_wr_o,
    output logic        perm_ex_o,
    output logic [1:0]  err_kind_o,
    output logic [11:0] exc_code_o,
    output logic        cacheable_o
);
    rgn_e rgn;
    err_e err;

    vad_region_class u_class (
        .vaddr_i (vaddr_i),
        .rgn_o   (rgn)
    );

    vad_access_check u_check (
        .vaddr_i     (vaddr_i),
        .rgn_i       (rgn),
        .acc_i       (acc_kind_i),
        .priv_i      (priv_i),
        .mmu_en_i    (mmu_en_i),
        .paddr_o     (paddr_o),
        .bypass_o    (bypass_o),
        .need_xlat_o (need_xlat_o),
        .err_o       (err),
        .exc_o       (exc_code_o)
    );

    vad_cache_attr u_cache (
        .rgn_i       (rgn),
        .priv_i      (priv_i),
        .cacheable_o (cacheable_o)
    );

    assign err_kind_o = err;

    // Bypass results carry full permission, other outcomes none.
    assign perm_rd_o = bypass_o;
    assign perm_wr_o = bypass_o;
    assign perm_ex_o = bypass_o;

    // Cross-checks between the classifier, the resolver and the ports.
    always_comb begin
        // R3: address errors arise only in user mode
        a_r3_err_user_only: assert (!(err_kind_o != 2'd0 && priv_i))
            else $error("address error in privileged mode");
        // R7: translation requests only when translation is enabled
        a_r7_xlat_needs_en: assert (!(need_xlat_o && !mmu_en_i))
            else $error("translation requested with translation off");
        // R7: outcomes are mutually exclusive
        a_r7_one_outcome: assert ($countones({bypass_o, need_xlat_o, err_kind_o != 2'd0}) == 1)
            else $error("not exactly one outcome");
        // R5: exception code matches the error kind
        a_r5_code_match: assert ((err_kind_o == 2'd0) == (exc_code_o == 12'h000))
            else $error("exception code inconsistent with error kind");
        // R1: below the control space a bypass address has its top bits cleared
        a_r1_masked_top: assert (!(bypass_o && vaddr_i[31:29] != 3'b111 && paddr_o[31:29] != 3'b000))
            else $error("bypass address not masked");
        // R9: user mode caches only the user region
        a_r9_user_cache: assert (!(cacheable_o && !priv_i && vaddr_i[31]))
            else $error("user-mode cacheable above user region");
    end
endmodule

// File: tb/vad_region_decoder_tb_top.sv
// Directed bench for the virtual address region decoder.
module vad_region_decoder_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic [31:0] vaddr;
    logic [1:0]  acc;
    logic        priv;
    logic        mmu_en;
    logic [31:0] paddr;
    logic        bypass, need_xlat, prd, pwr, pex, cacheable;
    logic [1:0]  err_kind;
    logic [11:0] exc_code;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vad_region_decoder dut_i (
        .vaddr_i     (vaddr),
        .acc_kind_i  (acc),
        .priv_i      (priv),
        .mmu_en_i    (mmu_en),
        .paddr_o     (paddr),
        .bypass_o    (bypass),
        .need_xlat_o (need_xlat),
        .perm_rd_o   (prd),
        .perm_wr_o   (pwr),
        .perm_ex_o   (pex),
        .err_kind_o  (err_kind),
        .exc_code_o  (exc_code),
        .cacheable_o (cacheable)
    );

    task automatic drive(input logic [31:0] a, input logic [1:0] k,
                         input logic p, input logic en);
        @(negedge clk);
        vaddr = a; acc = k; priv = p; mmu_en = en;
        #1;
    endtask

    task automatic expect_all(input string req, input logic [31:0] e_pa,
                              input logic e_byp, input logic e_xl,
                              input logic [1:0] e_err, input logic [11:0] e_exc,
                              input logic e_c);
        logic [3:0] e_perm;
        e_perm = {4{e_byp}};
        n_run++;
        if (paddr !== e_pa || bypass !== e_byp || need_xlat !== e_xl ||
            err_kind !== e_err || exc_code !== e_exc || cacheable !== e_c ||
            {prd, pwr, pex, bypass} !== e_perm) begin
            n_fail++;
            $display("FAIL %s va=%h: got pa=%h byp=%b xl=%b err=%0d exc=%h c=%b rwx=%b%b%b exp pa=%h byp=%b xl=%b err=%0d exc=%h c=%b",
                     req, vaddr, paddr, bypass, need_xlat, err_kind, exc_code, cacheable,
                     prd, pwr, pex, e_pa, e_byp, e_xl, e_err, e_exc, e_c);
        end
    endtask

    // All-zero inputs: user mode, translation off, low address.
    task automatic t_idle();
        drive(32'h0, 2'd0, 1'b0, 1'b0);
        expect_all("R6", 32'h0, 1, 0, 2'd0, 12'h000, 1);
    endtask

    task automatic t_priv_windows();
        drive(32'h8123_4567, 2'd0, 1'b1, 1'b1);
        expect_all("R1", 32'h0123_4567, 1, 0, 2'd0, 12'h000, 1);
        drive(32'hB000_0010, 2'd1, 1'b1, 1'b0);
        expect_all("R1", 32'h1000_0010, 1, 0, 2'd0, 12'h000, 0);
        drive(32'hFF00_0020, 2'd2, 1'b1, 1'b1);
        expect_all("R2", 32'hFF00_0020, 1, 0, 2'd0, 12'h000, 0);
        drive(32'hE000_0004, 2'd1, 1'b1, 1'b1);
        expect_all("R2", 32'hE000_0004, 1, 0, 2'd0, 12'h000, 0);
    endtask

    task automatic t_user_errors();
        drive(32'h8000_0000, 2'd0, 1'b0, 1'b1);
        expect_all("R3", 32'h0, 0, 0, 2'd1, 12'h0C0, 0);
        drive(32'hE400_0000, 2'd1, 1'b0, 1'b1);
        expect_all("R5", 32'h0, 0, 0, 2'd2, 12'h100, 0);
        drive(32'hA000_0000, 2'd2, 1'b0, 1'b1);
        expect_all("R4", 32'h0, 0, 0, 2'd3, 12'h0C0, 0);
        drive(32'h9000_0000, 2'd3, 1'b0, 1'b1);
        expect_all("R4", 32'h0, 0, 0, 2'd1, 12'h0C0, 0);
    endtask

    task automatic t_store_queue();
        drive(32'hE000_0000, 2'd1, 1'b0, 1'b1);
        expect_all("R3", 32'hE000_0000, 1, 0, 2'd0, 12'h000, 0);
        drive(32'hE3FF_FFFC, 2'd2, 1'b0, 1'b0);
        expect_all("R3", 32'hE3FF_FFFC, 1, 0, 2'd0, 12'h000, 0);
    endtask

    task automatic t_mmu_off();
        drive(32'h7FFF_FFFF, 2'd1, 1'b0, 1'b0);
        expect_all("R6", 32'h1FFF_FFFF, 1, 0, 2'd0, 12'h000, 1);
        drive(32'hD234_5678, 2'd0, 1'b1, 1'b0);
        expect_all("R6", 32'h1234_5678, 1, 0, 2'd0, 12'h000, 1);
        drive(32'h8000_0000, 2'd1, 1'b0, 1'b0);
        expect_all("R10", 32'h0, 0, 0, 2'd2, 12'h100, 0);
        drive(32'hFFFF_FFFF, 2'd0, 1'b1, 1'b0);
        expect_all("R10", 32'hFFFF_FFFF, 1, 0, 2'd0, 12'h000, 0);
    endtask

    task automatic t_translate();
        drive(32'h0000_1000, 2'd0, 1'b1, 1'b1);
        expect_all("R7", 32'h0, 0, 1, 2'd0, 12'h000, 1);
        drive(32'hC000_0000, 2'd2, 1'b0, 1'b1);
        expect_all("R7", 32'h0, 0, 1, 2'd0, 12'h000, 0);
        drive(32'hDFFF_FFFF, 2'd1, 1'b1, 1'b1);
        expect_all("R8", 32'h0, 0, 1, 2'd0, 12'h000, 1);
        drive(32'h7FFF_FFFC, 2'd2, 1'b0, 1'b1);
        expect_all("R9", 32'h0, 0, 1, 2'd0, 12'h000, 1);
    endtask

    initial begin
        vaddr = '0; acc = '0; priv = 1'b0; mmu_en = 1'b0;
        t_idle();
        t_priv_windows();
        t_user_errors();
        t_store_queue();
        t_mmu_off();
        t_translate();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule